// File: doc/BRIEF.md
# ATAPI packet command responder

This block sits behind the register file of an optical-drive style packet interface. Once the host has written a complete 12-byte command packet, the block decodes the packet and carries out the command. The possible outcomes are a completion, an error, or a data response. For a data response, the block writes the response bytes into the shared data buffer, one byte per cycle, and then strobes the transfer engine to start either a DMA read or a PIO read.

The block holds the device status and error registers. It also keeps a 10-byte sense array, which records the result of the most recent command. A fixed 32-byte identify table is computed in logic. Session information and sector reads are handed to an external media stub through a request/response handshake. The stub returns a 16-bit result, a length and (for sessions) six info bytes. Sector data never passes through this block.

Results are 16-bit codes. The result codes and opcodes are parameters. Their defaults are:

| Name | Value |
|---|---|
| OK | 0x0000 |
| NODISC | 0x3A02 |
| BADFIELD | 0x2405 |
| BADCMD | 0x2005 |
| test-ready opcode | 0x00 |
| identify opcode | 0x11 |
| request-sense opcode | 0x13 |
| session-query opcode | 0x14 |
| sector-read opcode | 0x30 |
| spin-up opcode | 0x70 |

Packet byte k lies on `pkt_bytes[8k+7:8k]`.

Top module: `atapi_pkt_responder`

## Requirements
- R1: After reset, `status_reg` is 0x50 and `error_reg` is 0x01. `buf_we`, `rd_start`, `irq_pulse` and `ext_req_valid` are all low.
- R2: A `pkt_valid` pulse is accepted only while status bit 7 (BSY) is clear. Acceptance sets BSY and clears bit 3 from the next cycle on. A pulse that arrives while BSY is set is ignored: it produces no event and does not change the outcome of the command in flight.
- R3: Recording a result R has two parts. In the sense array it sets byte 0 to 0xF0, byte 2 to R[7:0] and byte 8 to R[15:8]. It also sets `error_reg` to {R[3:0],4'h0}. A nonzero R additionally sets `status_reg` to 0x51 and gives one `irq_pulse`.
- R4: A data response writes its bytes to buffer addresses 0, 1, 2, … on consecutive cycles. One `rd_start` cycle follows the last byte and carries the byte count on `rd_len`. In that cycle a zero result is recorded, which clears only status bits 7 and 0.
- R5: Test-ready with `media_present` low records NODISC. With `media_present` high it records OK, sets status to 0x50 and gives one `irq_pulse`.
- R6: Identify returns table bytes starting at the offset in packet byte 2. The count is packet byte 4, clamped so that it does not run past byte 31. Table byte i equals ((29·i) mod 256) XOR 0xA5.
- R7: Identify with an offset of 32 or more sets status to 0x51 and `error_reg` to BADFIELD[7:0] (0x05). It writes no data, gives no interrupt and leaves the sense array unchanged.
- R8: Request-sense returns the sense array as it stood before the command, with the count in packet byte 4 clamped to 10.
- R9: The session query issues a stub request with `ext_req_sector`=0 and `ext_req_sel` = packet byte 2. On a zero stub result it returns the stub's info bytes, with the count from packet byte 4 clamped to 6. On a nonzero stub result it records that result.
- R10: A sector read whose mode byte (packet byte 1) is not 0x20, 0x24, 0x28 or 0x30 records BADFIELD and issues no stub request.
- R11: A valid sector read requests LBA = bytes 2,3,4 and count = bytes 8,9,10, each most significant byte first, with `ext_req_sector`=1. On success it starts a read of the stub-returned length without writing the buffer. On failure it records the stub result and also stores the LBA into sense bytes 5, 6 and 7, most significant byte first.
- R12: Spin-up records OK and gives one `irq_pulse`. An unrecognised opcode records BADCMD.
- R13: During `rd_start`, `rd_dma` equals `feat_dma` and `rd_blk` equals `byte_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Completed command packet strobe |
| pkt_bytes | input | 96 | Packet bytes, byte k at bits 8k+7:8k |
| feat_dma | input | 1 | Feature register DMA select |
| byte_count | input | 16 | Byte-count registers, used as block size |
| media_present | input | 1 | Media loaded |
| ext_req_valid | output | 1 | Stub request valid |
| ext_req_ready | input | 1 | Stub request accepted |
| ext_req_sector | output | 1 | 1 = sector read, 0 = session query |
| ext_req_sel | output | 8 | Session selector (packet byte 2) |
| ext_req_lba | output | 24 | Sector LBA |
| ext_req_count | output | 24 | Sector block count |
| ext_rsp_valid | input | 1 | Stub response strobe |
| ext_rsp_status | input | 16 | Stub result code |
| ext_rsp_len | input | 16 | Stub data length |
| ext_rsp_info | input | 48 | Session info bytes, byte k at 8k+7:8k |
| buf_we | output | 1 | Buffer byte write |
| buf_addr | output | 16 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rd_start | output | 1 | Start-read strobe to the transfer engine |
| rd_dma | output | 1 | Read by DMA (1) or PIO (0) |
| rd_len | output | 16 | Read byte count |
| rd_blk | output | 16 | PIO block size |
| irq_pulse | output | 1 | One-cycle interrupt request |
| status_reg | output | 8 | Device status register |
| error_reg | output | 8 | Device error register |

## Verification
Two functions can meet in the same cycle, and the bench provokes both.

- **Sense copy against result update.** The zero-result update that accompanies a read start touches the same sense bytes that a request-sense copies. The bench issues request-sense right after several failures. The scoreboard then expects the failing code in bytes 2 and 8 of the copy, and a second request-sense expects those bytes cleared.
- **Packet strobe during a busy command.** While a sector read waits on the stub, the bench pulses a new packet carrying an unknown opcode. The command is judged by the absence of any extra interrupt and by an unchanged status and length outcome.

// File: rtl/atapi_rsp_pkg.sv
package atapi_rsp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DECODE, ST_EXT_REQ, ST_EXT_WAIT, ST_COPY, ST_START
   } rsp_state_e;

   typedef enum logic [1:0] {
      SRC_IDENT, SRC_SENSE, SRC_INFO
   } copy_src_e;

   typedef enum logic [3:0] {
      ACT_TEST_OK, ACT_NODISC, ACT_SPIN, ACT_BADCMD, ACT_BADMODE,
      ACT_BADOFF, ACT_IDENT, ACT_SENSE, ACT_SESSION, ACT_SECTOR
   } pkt_act_e;

   localparam logic [7:0] ST_BSY        = 8'h80;
   localparam logic [7:0] ST_DRQ        = 8'h08;
   localparam logic [7:0] ST_CHK        = 8'h01;
   localparam logic [7:0] ST_READY_IDLE = 8'h50;
   localparam logic [7:0] ST_FAILED     = 8'h51;
   localparam logic [7:0] SENSE_TAG     = 8'hF0;

   // identify table entry: (29*i mod 256) xor 0xA5
   function automatic logic [7:0] ident_byte(input logic [7:0] i);
      return (i * 8'd29) ^ 8'hA5;
   endfunction

endpackage

// File: rtl/rsp_pkt_decode.sv
module rsp_pkt_decode
   import atapi_rsp_pkg::*;
#(
   parameter int          PKT_BYTES   = 12,
   parameter int          IDENT_BYTES = 32,
   parameter int          SENSE_BYTES = 10,
   parameter logic [7:0]  OP_TEST     = 8'h00,
   parameter logic [7:0]  OP_IDENT    = 8'h11,
   parameter logic [7:0]  OP_SENSE    = 8'h13,
   parameter logic [7:0]  OP_SESSION  = 8'h14,
   parameter logic [7:0]  OP_SECTOR   = 8'h30,
   parameter logic [7:0]  OP_SPIN     = 8'h70
) (
   input  logic [PKT_BYTES*8-1:0] pkt,
   input  logic                   media_present,
   output pkt_act_e               act,
   output logic [7:0]             copy_len,
   output logic [7:0]             copy_base,
   output logic [7:0]             req_len,
   output logic [7:0]             sel,
   output logic [23:0]            lba,
   output logic [23:0]            count
);

   logic [7:0] op, mode, off;
   logic [8:0] room;
   logic       unused_bytes;

   assign op        = pkt[7:0];
   assign mode      = pkt[15:8];
   assign off       = pkt[23:16];
   assign req_len   = pkt[39:32];
   assign sel       = off;
   assign copy_base = off;
   assign lba       = {pkt[23:16], pkt[31:24], pkt[39:32]};
   assign count     = {pkt[71:64], pkt[79:72], pkt[87:80]};
   assign room      = 9'(IDENT_BYTES) - {1'b0, off};
   assign unused_bytes = ^{pkt[63:40], pkt[PKT_BYTES*8-1:88]};

   always_comb begin
      act      = ACT_BADCMD;
      copy_len = 8'd0;
      if (op == OP_TEST) begin
         act = media_present ? ACT_TEST_OK : ACT_NODISC;
      end else if (op == OP_IDENT) begin
         if ({1'b0, off} >= 9'(IDENT_BYTES)) begin
            act = ACT_BADOFF;
         end else begin
            act      = ACT_IDENT;
            copy_len = ({1'b0, req_len} > room) ? room[7:0] : req_len;
         end
      end else if (op == OP_SENSE) begin
         act      = ACT_SENSE;
         copy_len = (req_len > 8'(SENSE_BYTES)) ? 8'(SENSE_BYTES) : req_len;
      end else if (op == OP_SESSION) begin
         act = ACT_SESSION;
      end else if (op == OP_SECTOR) begin
         if (mode == 8'h20 || mode == 8'h24 || mode == 8'h28 || mode == 8'h30)
            act = ACT_SECTOR;
         else
            act = ACT_BADMODE;
      end else if (op == OP_SPIN) begin
         act = ACT_SPIN;
      end
   end

endmodule

// File: rtl/rsp_sense_store.sv
module rsp_sense_store
   import atapi_rsp_pkg::*;
#(
   parameter int SENSE_BYTES = 10,
   localparam int SIW = $clog2(SENSE_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           res_we,
   input  logic [15:0]    res_code,
   input  logic           lba_we,
   input  logic [23:0]    lba,
   input  logic [SIW-1:0] rd_idx,
   output logic [7:0]     rd_byte
);

   logic [7:0] sense_q [SENSE_BYTES];

   generate
      if (SENSE_BYTES < 9 || SENSE_BYTES > 16) begin : g_bad_size
         $error("rsp_sense_store: SENSE_BYTES must lie in 9..16");
      end
      for (genvar g = 0; g < SENSE_BYTES; g++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sense_q[g] <= 8'h00;
            else if (res_we && g == 0)
               sense_q[g] <= SENSE_TAG;
            else if (res_we && g == 2)
               sense_q[g] <= res_code[7:0];
            else if (res_we && g == 8)
               sense_q[g] <= res_code[15:8];
            else if (lba_we && g == 5)
               sense_q[g] <= lba[23:16];
            else if (lba_we && g == 6)
               sense_q[g] <= lba[15:8];
            else if (lba_we && g == 7)
               sense_q[g] <= lba[7:0];
         end
      end
   endgenerate

   always_comb begin
      rd_byte = 8'h00;
      for (int k = 0; k < SENSE_BYTES; k++)
         if (rd_idx == SIW'(k)) rd_byte = sense_q[k];
   end

endmodule

// File: rtl/atapi_pkt_responder.sv
module atapi_pkt_responder
   import atapi_rsp_pkg::*;
#(
   parameter int          PKT_BYTES    = 12,
   parameter int          IDENT_BYTES  = 32,
   parameter int          SENSE_BYTES  = 10,
   parameter int          INFO_BYTES   = 6,
   parameter int          LENW         = 16,
   parameter int          BLKW         = 16,
   parameter logic [7:0]  OP_TEST      = 8'h00,
   parameter logic [7:0]  OP_IDENT     = 8'h11,
   parameter logic [7:0]  OP_SENSE     = 8'h13,
   parameter logic [7:0]  OP_SESSION   = 8'h14,
   parameter logic [7:0]  OP_SECTOR    = 8'h30,
   parameter logic [7:0]  OP_SPIN      = 8'h70,
   parameter logic [15:0] RES_OK       = 16'h0000,
   parameter logic [15:0] RES_NODISC   = 16'h3A02,
   parameter logic [15:0] RES_BADFIELD = 16'h2405,
   parameter logic [15:0] RES_BADCMD   = 16'h2005
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pkt_valid,
   input  logic [PKT_BYTES*8-1:0]  pkt_bytes,
   input  logic                    feat_dma,
   input  logic [BLKW-1:0]         byte_count,
   input  logic                    media_present,
   output logic                    ext_req_valid,
   input  logic                    ext_req_ready,
   output logic                    ext_req_sector,
   output logic [7:0]              ext_req_sel,
   output logic [23:0]             ext_req_lba,
   output logic [23:0]             ext_req_count,
   input  logic                    ext_rsp_valid,
   input  logic [15:0]             ext_rsp_status,
   input  logic [LENW-1:0]         ext_rsp_len,
   input  logic [INFO_BYTES*8-1:0] ext_rsp_info,
   output logic                    buf_we,
   output logic [LENW-1:0]         buf_addr,
   output logic [7:0]              buf_wdata,
   output logic                    rd_start,
   output logic                    rd_dma,
   output logic [LENW-1:0]         rd_len,
   output logic [BLKW-1:0]         rd_blk,
   output logic                    irq_pulse,
   output logic [7:0]              status_reg,
   output logic [7:0]              error_reg
);

   localparam int SIW = $clog2(SENSE_BYTES);

   generate
      if (PKT_BYTES < 12) begin : g_chk_pkt
         $error("atapi_pkt_responder: PKT_BYTES below 12");
      end
      if (IDENT_BYTES < 1 || IDENT_BYTES > 255) begin : g_chk_ident
         $error("atapi_pkt_responder: IDENT_BYTES out of range");
      end
      if (INFO_BYTES < 1 || INFO_BYTES > 255) begin : g_chk_info
         $error("atapi_pkt_responder: INFO_BYTES out of range");
      end
      if (LENW < 8) begin : g_chk_lenw
         $error("atapi_pkt_responder: LENW below 8");
      end
      if (RES_OK != 16'h0) begin : g_chk_ok
         $error("atapi_pkt_responder: RES_OK must be zero");
      end
      if (RES_NODISC == 16'h0 || RES_BADFIELD == 16'h0 || RES_BADCMD == 16'h0 ||
          RES_NODISC == RES_BADFIELD || RES_NODISC == RES_BADCMD ||
          RES_BADFIELD == RES_BADCMD) begin : g_chk_codes
         $error("atapi_pkt_responder: error codes must be distinct and nonzero");
      end
   endgenerate

   rsp_state_e                st_q;
   copy_src_e                 src_q;
   logic [PKT_BYTES*8-1:0]    pkt_q;
   logic [LENW-1:0]           len_q, idx_q;
   logic [7:0]                base_q;
   logic [INFO_BYTES*8-1:0]   info_q;
   logic                      ext_sector_q;
   logic [7:0]                status_q, error_q;
   logic                      irq_q;

   pkt_act_e                  dec_act;
   logic [7:0]                dec_len, dec_base, dec_req_len, dec_sel;
   logic [23:0]               dec_lba, dec_count;
   logic [LENW-1:0]           ses_len;

   logic                      res_we, lba_we;
   logic [15:0]               res_code;
   logic [7:0]                sense_byte, copy_byte;

   rsp_pkt_decode #(
      .PKT_BYTES  (PKT_BYTES),
      .IDENT_BYTES(IDENT_BYTES),
      .SENSE_BYTES(SENSE_BYTES),
      .OP_TEST    (OP_TEST),
      .OP_IDENT   (OP_IDENT),
      .OP_SENSE   (OP_SENSE),
      .OP_SESSION (OP_SESSION),
      .OP_SECTOR  (OP_SECTOR),
      .OP_SPIN    (OP_SPIN)
   ) u_decode (
      .pkt          (pkt_q),
      .media_present(media_present),
      .act          (dec_act),
      .copy_len     (dec_len),
      .copy_base    (dec_base),
      .req_len      (dec_req_len),
      .sel          (dec_sel),
      .lba          (dec_lba),
      .count        (dec_count)
   );

   rsp_sense_store #(
      .SENSE_BYTES(SENSE_BYTES)
   ) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .res_we  (res_we),
      .res_code(res_code),
      .lba_we  (lba_we),
      .lba     (dec_lba),
      .rd_idx  (idx_q[SIW-1:0]),
      .rd_byte (sense_byte)
   );

   assign ses_len = (dec_req_len > 8'(INFO_BYTES)) ? LENW'(INFO_BYTES) : LENW'(dec_req_len);

   // result recording requests
   always_comb begin
      res_we   = 1'b0;
      lba_we   = 1'b0;
      res_code = RES_OK;
      case (st_q)
         ST_DECODE: begin
            case (dec_act)
               ACT_TEST_OK, ACT_SPIN: res_we = 1'b1;
               ACT_NODISC:  begin res_we = 1'b1; res_code = RES_NODISC;   end
               ACT_BADCMD:  begin res_we = 1'b1; res_code = RES_BADCMD;   end
               ACT_BADMODE: begin res_we = 1'b1; res_code = RES_BADFIELD; end
               default: ;
            endcase
         end
         ST_EXT_WAIT: begin
            if (ext_rsp_valid && ext_rsp_status != RES_OK) begin
               res_we   = 1'b1;
               res_code = ext_rsp_status;
               lba_we   = ext_sector_q;
            end
         end
         ST_START: res_we = 1'b1;
         default: ;
      endcase
   end

   // response byte source
   always_comb begin
      copy_byte = 8'h00;
      case (src_q)
         SRC_IDENT: copy_byte = ident_byte(base_q + idx_q[7:0]);
         SRC_SENSE: copy_byte = sense_byte;
         default: begin
            for (int k = 0; k < INFO_BYTES; k++)
               if (idx_q == LENW'(k)) copy_byte = info_q[k*8 +: 8];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         src_q        <= SRC_IDENT;
         pkt_q        <= '0;
         len_q        <= '0;
         idx_q        <= '0;
         base_q       <= '0;
         info_q       <= '0;
         ext_sector_q <= 1'b0;
         status_q     <= ST_READY_IDLE;
         error_q      <= 8'h01;
         irq_q        <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (res_we) begin
            error_q <= {res_code[3:0], 4'h0};
            if (res_code != RES_OK) begin
               status_q <= ST_FAILED;
               irq_q    <= 1'b1;
            end else begin
               status_q <= status_q & ~(ST_BSY | ST_CHK);
            end
         end
         case (st_q)
            ST_IDLE: begin
               if (pkt_valid) begin
                  pkt_q    <= pkt_bytes;
                  status_q <= (status_q | ST_BSY) & ~ST_DRQ;
                  st_q     <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               st_q   <= ST_IDLE;
               idx_q  <= '0;
               base_q <= dec_base;
               case (dec_act)
                  ACT_TEST_OK: begin
                     status_q <= ST_READY_IDLE;
                     irq_q    <= 1'b1;
                  end
                  ACT_SPIN: irq_q <= 1'b1;
                  ACT_BADOFF: begin
                     status_q <= ST_FAILED;
                     error_q  <= RES_BADFIELD[7:0];
                  end
                  ACT_IDENT, ACT_SENSE: begin
                     src_q <= (dec_act == ACT_IDENT) ? SRC_IDENT : SRC_SENSE;
                     len_q <= LENW'(dec_len);
                     st_q  <= (dec_len == 8'd0) ? ST_START : ST_COPY;
                  end
                  ACT_SESSION: begin
                     ext_sector_q <= 1'b0;
                     st_q         <= ST_EXT_REQ;
                  end
                  ACT_SECTOR: begin
                     ext_sector_q <= 1'b1;
                     st_q         <= ST_EXT_REQ;
                  end
                  default: ;
               endcase
            end
            ST_EXT_REQ: begin
               if (ext_req_ready) st_q <= ST_EXT_WAIT;
            end
            ST_EXT_WAIT: begin
               if (ext_rsp_valid) begin
                  if (ext_rsp_status != RES_OK) begin
                     st_q <= ST_IDLE;
                  end else if (ext_sector_q) begin
                     len_q <= ext_rsp_len;
                     st_q  <= ST_START;
                  end else begin
                     info_q <= ext_rsp_info;
                     src_q  <= SRC_INFO;
                     len_q  <= ses_len;
                     st_q   <= (ses_len == '0) ? ST_START : ST_COPY;
                  end
               end
            end
            ST_COPY: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == len_q - 1'b1) st_q <= ST_START;
            end
            ST_START: st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign ext_req_valid  = (st_q == ST_EXT_REQ);
   assign ext_req_sector = ext_sector_q;
   assign ext_req_sel    = dec_sel;
   assign ext_req_lba    = dec_lba;
   assign ext_req_count  = dec_count;
   assign buf_we         = (st_q == ST_COPY);
   assign buf_addr       = idx_q;
   assign buf_wdata      = copy_byte;
   assign rd_start       = (st_q == ST_START);
   assign rd_dma         = feat_dma;
   assign rd_len         = len_q;
   assign rd_blk         = byte_count;
   assign irq_pulse      = irq_q;
   assign status_reg     = status_q;
   assign error_reg      = error_q;

endmodule

// File: rtl/atapi_pkt_responder_chk.sv
module atapi_pkt_responder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pkt_valid,
   input logic [7:0]  status_reg,
   input logic [7:0]  error_reg,
   input logic        buf_we,
   input logic        rd_start,
   input logic        irq_pulse,
   input logic        ext_req_valid,
   input logic        ext_req_ready,
   input logic [23:0] ext_req_lba,
   input logic [23:0] ext_req_count
);

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !status_reg[7]) |=> status_reg[7]);

   // R4
   copy_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (status_reg[7] && !rd_start));

   // R4
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> (!status_reg[7] && !status_reg[0] && error_reg == 8'h00));

   // R3
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !status_reg[7]);

   // R11
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req_valid && !ext_req_ready) |=>
         (ext_req_valid && $stable(ext_req_lba) && $stable(ext_req_count)));

endmodule

bind atapi_pkt_responder atapi_pkt_responder_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pkt_valid    (pkt_valid),
   .status_reg   (status_reg),
   .error_reg    (error_reg),
   .buf_we       (buf_we),
   .rd_start     (rd_start),
   .irq_pulse    (irq_pulse),
   .ext_req_valid(ext_req_valid),
   .ext_req_ready(ext_req_ready),
   .ext_req_lba  (ext_req_lba),
   .ext_req_count(ext_req_count)
);

// File: tb/atapi_pkt_responder_bench.sv
module atapi_pkt_responder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [95:0] pkt_bytes = '0;
   logic        feat_dma = 1'b0;
   logic [15:0] byte_count = 16'h0800;
   logic        media_present = 1'b1;
   logic        ext_req_valid, ext_req_ready = 1'b0, ext_req_sector;
   logic [7:0]  ext_req_sel;
   logic [23:0] ext_req_lba, ext_req_count;
   logic        ext_rsp_valid = 1'b0;
   logic [15:0] ext_rsp_status = '0, ext_rsp_len = '0;
   logic [47:0] ext_rsp_info = '0;
   logic        buf_we, rd_start, rd_dma, irq_pulse;
   logic [15:0] buf_addr, rd_len, rd_blk;
   logic [7:0]  buf_wdata, status_reg, error_reg;

   always #4 clk = ~clk;   // 125 MHz

   atapi_pkt_responder u_atapi_pkt_responder (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes),
      .feat_dma(feat_dma), .byte_count(byte_count), .media_present(media_present),
      .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready),
      .ext_req_sector(ext_req_sector), .ext_req_sel(ext_req_sel),
      .ext_req_lba(ext_req_lba), .ext_req_count(ext_req_count),
      .ext_rsp_valid(ext_rsp_valid), .ext_rsp_status(ext_rsp_status),
      .ext_rsp_len(ext_rsp_len), .ext_rsp_info(ext_rsp_info),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .rd_start(rd_start), .rd_dma(rd_dma), .rd_len(rd_len), .rd_blk(rd_blk),
      .irq_pulse(irq_pulse), .status_reg(status_reg), .error_reg(error_reg)
   );

   typedef struct { int kind; int a; int b; int c; } ev_t;  // 0 write, 1 start, 2 irq
   ev_t expq[$];
   int  checks = 0, fails = 0, ext_seen = 0;
   bit  done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ib(input int i);
      return ((i * 29) & 255) ^ 'hA5;
   endfunction

   function automatic logic [95:0] pk(input logic [7:0] b0, b1, b2, b4,
                                      input logic [7:0] b3 = 0, b8 = 0, b9 = 0, b10 = 0);
      logic [95:0] p = '0;
      p[7:0] = b0; p[15:8] = b1; p[23:16] = b2; p[31:24] = b3; p[39:32] = b4;
      p[71:64] = b8; p[79:72] = b9; p[87:80] = b10;
      return p;
   endfunction

   task automatic exp_wr(input int a, input int d);
      ev_t e = '{0, a, d, 0}; expq.push_back(e);
   endtask
   task automatic exp_start(input int len, input int dma);
      ev_t e = '{1, len, dma, int'(byte_count)}; expq.push_back(e);
   endtask
   task automatic exp_irq();
      ev_t e = '{2, 0, 0, 0}; expq.push_back(e);
   endtask

   task automatic pop_check(input int kind, input int a, input int b, input int c);
      ev_t e;
      if (expq.size() == 0) begin
         chk("R2 R4 unexpected scoreboard event kind", kind, -1);
      end else begin
         e = expq.pop_front();
         chk("R4 R12 scoreboard event kind", kind, e.kind);
         chk("R4 R6 R8 scoreboard field a (addr/len)", a, e.a);
         chk("R4 R13 scoreboard field b (data/dma)", b, e.b);
         chk("R13 scoreboard field c (block size)", c, e.c);
      end
   endtask

   // monitor
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (buf_we)        pop_check(0, int'(buf_addr), int'(buf_wdata), 0);
         if (rd_start)      pop_check(1, int'(rd_len), int'(rd_dma), int'(rd_blk));
         if (irq_pulse)     pop_check(2, 0, 0, 0);
         if (ext_req_valid) ext_seen++;
      end
   end

   task automatic send(input logic [95:0] p);
      @(negedge clk);
      pkt_bytes = p;
      pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
      #1 chk("R2 BSY set after accept", int'(status_reg[7]), 1);
   endtask

   task automatic wait_idle();
      int n = 0;
      while (status_reg[7] && n < 200) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
      #1 chk("R4 scoreboard drained", expq.size(), 0);
   endtask

   task automatic serve(input bit sector, input int sel, input int lba, input int cnt,
                        input int st, input int len, input logic [47:0] info,
                        input bit intrude);
      int n = 0;
      while (!ext_req_valid && n < 50) begin
         @(negedge clk);
         #1 n++;
      end
      chk("R9 R11 stub request kind", int'(ext_req_sector), int'(sector));
      if (sector) begin
         chk("R11 stub LBA", int'(ext_req_lba), lba);
         chk("R11 stub count", int'(ext_req_count), cnt);
      end else begin
         chk("R9 stub selector", int'(ext_req_sel), sel);
      end
      ext_req_ready = 1'b1;
      @(negedge clk);
      ext_req_ready = 1'b0;
      if (intrude) begin
         pkt_bytes = pk(8'h55, 0, 0, 0);
         pkt_valid = 1'b1;
         @(negedge clk);
         pkt_valid = 1'b0;
         #1 chk("R2 still busy while waiting on stub", int'(status_reg[7]), 1);
      end
      @(negedge clk);
      ext_rsp_status = 16'(st);
      ext_rsp_len    = 16'(len);
      ext_rsp_info   = info;
      ext_rsp_valid  = 1'b1;
      @(negedge clk);
      ext_rsp_valid  = 1'b0;
   endtask

   task automatic expect_sense(input int b [10]);
      for (int k = 0; k < 10; k++) exp_wr(k, b[k]);
      exp_start(10, int'(feat_dma));
      send(pk(8'h13, 0, 0, 8'd10));
      wait_idle();
   endtask

   task automatic regs(input string req, input int st, input int er);
      chk({req, " status"}, int'(status_reg), st);
      chk({req, " error"},  int'(error_reg), er);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      #1;
      // R1
      regs("R1 reset", 'h50, 'h01);
      chk("R1 reset outputs idle", int'({buf_we, rd_start, irq_pulse, ext_req_valid}), 0);
      rst_n = 1'b1;

      // R12 unknown opcode -> BADCMD, then R8 sense shows the old error bytes
      exp_irq();
      send(pk(8'h55, 0, 0, 0));
      wait_idle();
      regs("R12 R3 bad command", 'h51, 'h50);
      expect_sense('{'hF0, 0, 'h05, 0, 0, 0, 0, 0, 'h20, 0});
      regs("R4 zero result after sense read", 'h50, 'h00);

      // R8 clamp to 10 and cleared result fields
      for (int k = 0; k < 10; k++) exp_wr(k, k == 0 ? 'hF0 : 0);
      exp_start(10, 0);
      send(pk(8'h13, 0, 0, 8'd20));
      wait_idle();

      // R5 test-ready with and without media
      exp_irq();
      send(pk(8'h00, 0, 0, 0));
      wait_idle();
      regs("R5 test-ready media", 'h50, 'h00);
      media_present = 1'b0;
      exp_irq();
      send(pk(8'h00, 0, 0, 0));
      wait_idle();
      regs("R5 test-ready no disc", 'h51, 'h20);
      expect_sense('{'hF0, 0, 'h02, 0, 0, 0, 0, 0, 'h3A, 0});
      media_present = 1'b1;

      // R6 identify, DMA variant (R13)
      feat_dma = 1'b1;
      for (int k = 0; k < 8; k++) exp_wr(k, ib(4 + k));
      exp_start(8, 1);
      send(pk(8'h11, 0, 8'd4, 8'd8));
      wait_idle();
      for (int k = 0; k < 4; k++) exp_wr(k, ib(28 + k));
      exp_start(4, 1);
      send(pk(8'h11, 0, 8'd28, 8'd10));
      wait_idle();
      regs("R6 identify clamp", 'h50, 'h00);
      feat_dma = 1'b0;
      byte_count = 16'h0930;

      // R7 identify offset out of table
      send(pk(8'h11, 0, 8'd32, 8'd4));
      wait_idle();
      regs("R7 identify bad offset", 'h51, 'h05);
      expect_sense('{'hF0, 0, 0, 0, 0, 0, 0, 0, 0, 0});

      // R12 spin-up after an error
      exp_irq();
      send(pk(8'h66, 0, 0, 0));
      wait_idle();
      exp_irq();
      send(pk(8'h70, 0, 0, 0));
      wait_idle();
      regs("R12 spin-up", 'h50, 'h00);

      // R9 session query ok and failing
      for (int k = 0; k < 6; k++) exp_wr(k, 'h11 + k);
      exp_start(6, 0);
      send(pk(8'h14, 0, 8'd1, 8'd9));
      serve(1'b0, 1, 0, 0, 0, 0, 48'h161514131211, 1'b0);
      wait_idle();
      exp_irq();
      send(pk(8'h14, 0, 8'd2, 8'd6));
      serve(1'b0, 2, 0, 0, 'h0206, 0, '0, 1'b0);
      wait_idle();
      regs("R9 session failure", 'h51, 'h60);
      expect_sense('{'hF0, 0, 'h06, 0, 0, 0, 0, 0, 'h02, 0});

      // R10 bad mode byte: no stub request
      seen = ext_seen;
      exp_irq();
      send(pk(8'h30, 8'h22, 8'h01, 8'h02));
      wait_idle();
      regs("R10 bad read mode", 'h51, 'h50);
      chk("R10 no stub request", ext_seen, seen);

      // R11 good sector read with an ignored packet (R2) while waiting
      exp_start('h930, 0);
      send(pk(8'h30, 8'h24, 8'h12, 8'h56, 8'h34, 8'h00, 8'h00, 8'h10));
      serve(1'b1, 0, 'h123456, 'h10, 0, 'h930, '0, 1'b1);
      wait_idle();
      regs("R11 R2 sector read ok", 'h50, 'h00);

      // R11 failing sector read stores LBA in sense
      exp_irq();
      send(pk(8'h30, 8'h30, 8'hAB, 8'hEF, 8'hCD, 8'h00, 8'h00, 8'h01));
      serve(1'b1, 0, 'hABCDEF, 1, 'h0304, 0, '0, 1'b0);
      wait_idle();
      regs("R11 sector failure", 'h51, 'h40);
      expect_sense('{'hF0, 0, 'h04, 0, 0, 'hAB, 'hCD, 'hEF, 'h03, 0});

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule